// File: doc/BRIEF.md
# Shared-Bus One-Time-Programmable Byte Memory Read Port

This block is a synthesizable, cycle-based model of a byte-wide one-time-programmable memory. The low address byte and the data byte share one 8-bit bus. A host first presents the low address byte on the bus with the latch strobe `ale` high. It then lowers `ale`, drives the upper address bits on `addr_hi` and lowers `oe_n`. After both access delays have elapsed, the block drives the addressed byte, flagged by `bus_drive`. The bus is modelled as an input vector plus an output vector with a drive flag, not as a true tri-state pin.

While `ale` is high the device is in standby and never drives the bus. While `oe_n` is high the bus is released. A dedicated `id_mode` input, qualified by upper address bit 1, replaces the stored byte with one of two fixed identifier bytes. The storage array starts fully erased (every bit 1). A host-side load port can only clear bits, which mimics a one-time-programmable cell. The default upper-address width is 3 bits (2 KiB of storage), which keeps elaboration small; `HI_W = 8` gives the full 64 KiB arrangement. The access delays are counted in clock cycles: 18 and 9 cycles by default, about 70 ns and 35 ns at a 4 ns clock.

Top module: `mxb_otp_rom`

## Requirements
- R1: While `rst` is high and on the first edge after it, `bus_drive` is 0 and `bus_out` is 0x00.
- R2: At every rising edge where `ale` is 1, the low address byte is captured from `bus_in`. While `ale` is 0, the captured byte is held no matter what `bus_in` carries.
- R3: When driving in read mode, `bus_out` equals the stored byte at address `{addr_hi, latched low byte}`. The array read is registered: the byte shown after edge n was read with the address present at edge n-1.
- R4: After any edge where `oe_n` is 1, `bus_drive` is 0. Whenever `bus_drive` is 0, `bus_out` is 0x00.
- R5: After any edge where `ale` is 1 (standby), `bus_drive` is 0.
- R6: `bus_drive` rises only after `ale` has been sampled 0 on at least ALE_CYC+1 consecutive edges, counting the current edge.
- R7: `bus_drive` rises only after `oe_n` has been sampled 0 on at least OE_CYC+1 consecutive edges, counting the current edge. When R6 and R7 are both met and `ale`=0 and `oe_n`=0, `bus_drive` is 1 after that edge.
- R8: Identification applies when `id_mode`=1, `addr_hi[1]`=1 and every `addr_hi` bit above bit 1 is 0. Driven data is then 0x1E if `addr_hi[0]`=0 and 0x9D if `addr_hi[0]`=1, taken from `addr_hi` at the same edge.
- R9: When `id_mode`=1 but the R8 condition fails (bit 1 low or a higher bit set), `id_mode` is ignored and the stored byte is returned.
- R10: A byte never loaded reads as 0xFF.
- R11: A load at edge n with `ld_en`=1 sets the byte at `ld_addr` to old AND `ld_data`. Bits can only go from 1 to 0.
- R12: When a load and a read of the same byte fall on the same edge, that edge's array read returns the old byte. The next edge's read returns the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ale | input | 1 | Latch strobe; high captures low address and selects standby |
| oe_n | input | 1 | Active-low output enable |
| addr_hi | input | HI_W | Upper address bits |
| id_mode | input | 1 | Identification request, qualified by addr_hi[1] |
| bus_in | input | DW | Shared bus as seen by the device (low address byte) |
| bus_out | output | DW | Shared bus value driven by the device |
| bus_drive | output | 1 | High when the device drives the shared bus |
| ld_en | input | 1 | Host load strobe |
| ld_addr | input | HI_W+DW | Host load address |
| ld_data | input | DW | Host load value; only its 0 bits take effect |

## Verification
The load port and the read path can touch the same byte on the same edge. The bench provokes this while a read of that byte is already being driven, by pulsing `ld_en` at the byte's address mid-access. Random loads also land on the active address from time to time. The bench's reference model reads its copy of the array before applying the AND, so one driven cycle must still show the old byte and the cycle after must show the cleared bits. A write-first or unregistered array shows up as a one-cycle-early mismatch.

// File: rtl/otp_pkg.sv
package otp_pkg;

  typedef enum logic [1:0] {
    MODE_STANDBY = 2'd0,
    MODE_RELEASE = 2'd1,
    MODE_ARRAY   = 2'd2,
    MODE_IDENT   = 2'd3
  } otp_mode_e;

  localparam logic [7:0] ID_MAKER  = 8'h1E;
  localparam logic [7:0] ID_DEVICE = 8'h9D;

  function automatic logic mode_drives(otp_mode_e m);
    return (m == MODE_ARRAY) || (m == MODE_IDENT);
  endfunction

endpackage

// File: rtl/otp_lo_latch.sv
module otp_lo_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         capture,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (capture) q <= d;
  end
endmodule

// File: rtl/otp_run_cnt.sv
module otp_run_cnt #(
  parameter int LIMIT = 18
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic done
);
  localparam int CW = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  // done means the qualifying level was seen on LIMIT prior edges
  assign done = (cnt == LIM);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (!done) cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_mask,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  // erased state: every bit set
  initial begin
    for (int i = 0; i < DEPTH; i++) cells[i] = '1;
  end

  // bits can only be cleared
  always_ff @(posedge clk) begin
    if (ld_en) cells[ld_addr] <= cells[ld_addr] & ld_mask;
  end

  // read-first registered port
  always_ff @(posedge clk) begin
    rd_q <= cells[rd_addr];
  end
endmodule

// File: rtl/otp_id_dec.sv
module otp_id_dec #(
  parameter int HI_W = 3,
  parameter int DW   = 8
) (
  input  logic [HI_W-1:0] hi,
  input  logic            id_req,
  output logic            hit,
  output logic [DW-1:0]   code
);
  import otp_pkg::*;

  logic upper_clear;

  generate
    if (HI_W > 2) begin : g_upper
      assign upper_clear = (hi[HI_W-1:2] == '0);
    end else begin : g_none
      assign upper_clear = 1'b1;
    end
  endgenerate

  assign hit  = id_req && hi[1] && upper_clear;
  assign code = hi[0] ? DW'(ID_DEVICE) : DW'(ID_MAKER);
endmodule

// File: rtl/mxb_otp_rom.sv
module mxb_otp_rom #(
  parameter int HI_W    = 3,
  parameter int DW      = 8,
  parameter int ALE_CYC = 18,
  parameter int OE_CYC  = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ale,
  input  logic               oe_n,
  input  logic [HI_W-1:0]    addr_hi,
  input  logic               id_mode,
  input  logic [DW-1:0]      bus_in,
  output logic [DW-1:0]      bus_out,
  output logic               bus_drive,
  input  logic               ld_en,
  input  logic [HI_W+DW-1:0] ld_addr,
  input  logic [DW-1:0]      ld_data
);
  import otp_pkg::*;

  localparam int AW = HI_W + DW;

  logic [DW-1:0] lat_q;
  logic          ale_ok;
  logic          oe_ok;
  logic [DW-1:0] rd_q;
  logic          id_hit;
  logic [DW-1:0] id_code;
  otp_mode_e     mode;
  logic          drive_nx;
  logic [DW-1:0] data_nx;

  otp_lo_latch #(.W(DW)) u_latch (
    .clk(clk), .rst(rst), .capture(ale), .d(bus_in), .q(lat_q)
  );

  otp_run_cnt #(.LIMIT(ALE_CYC)) u_ale_cnt (
    .clk(clk), .rst(rst), .clr(ale), .done(ale_ok)
  );

  otp_run_cnt #(.LIMIT(OE_CYC)) u_oe_cnt (
    .clk(clk), .rst(rst), .clr(oe_n), .done(oe_ok)
  );

  otp_cell_array #(.AW(AW), .DW(DW)) u_array (
    .clk(clk), .ld_en(ld_en), .ld_addr(ld_addr), .ld_mask(ld_data),
    .rd_addr({addr_hi, lat_q}), .rd_q(rd_q)
  );

  otp_id_dec #(.HI_W(HI_W), .DW(DW)) u_id (
    .hi(addr_hi), .id_req(id_mode), .hit(id_hit), .code(id_code)
  );

  always_comb begin
    if (ale)         mode = MODE_STANDBY;
    else if (oe_n)   mode = MODE_RELEASE;
    else if (id_hit) mode = MODE_IDENT;
    else             mode = MODE_ARRAY;
  end

  assign drive_nx = mode_drives(mode) && ale_ok && oe_ok;
  assign data_nx  = !drive_nx ? '0 : (mode == MODE_IDENT) ? id_code : rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_drive <= 1'b0;
      bus_out   <= '0;
    end else begin
      bus_drive <= drive_nx;
      bus_out   <= data_nx;
    end
  end
endmodule

// File: rtl/mxb_otp_rom_chk.sv
module mxb_otp_rom_chk #(
  parameter int HI_W = 3,
  parameter int DW   = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            ale,
  input logic            oe_n,
  input logic [HI_W-1:0] addr_hi,
  input logic            id_mode,
  input logic [DW-1:0]   bus_in,
  input logic [DW-1:0]   bus_out,
  input logic            bus_drive,
  input logic [DW-1:0]   lat_q
);
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!bus_drive && bus_out == '0)); // R1
  AST_LATCH_TAKE: assert property (@(posedge clk) disable iff (rst) ale |=> lat_q == $past(bus_in)); // R2
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst) !ale |=> $stable(lat_q)); // R2
  AST_OE_RELEASE: assert property (@(posedge clk) disable iff (rst) oe_n |=> !bus_drive); // R4
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst) !bus_drive |-> bus_out == '0); // R4
  AST_STANDBY_FLOAT: assert property (@(posedge clk) disable iff (rst) ale |=> !bus_drive); // R5
  AST_DRIVE_NEEDS_ALE: assert property (@(posedge clk) disable iff (rst) $rose(bus_drive) |-> !$past(ale, 2)); // R6
  AST_DRIVE_NEEDS_OE: assert property (@(posedge clk) disable iff (rst) $rose(bus_drive) |-> !$past(oe_n, 2)); // R7
  AST_ID_CODE: assert property (@(posedge clk) disable iff (rst)
    (bus_drive && $past(id_mode) && $past(addr_hi[1]) && (($past(addr_hi) >> 2) == '0))
    |-> bus_out == ($past(addr_hi[0]) ? DW'(8'h9D) : DW'(8'h1E))); // R8
endmodule

bind mxb_otp_rom mxb_otp_rom_chk #(.HI_W(HI_W), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .ale(ale), .oe_n(oe_n), .addr_hi(addr_hi),
  .id_mode(id_mode), .bus_in(bus_in), .bus_out(bus_out),
  .bus_drive(bus_drive), .lat_q(lat_q)
);

// File: tb/mxb_otp_rom_tb.sv
module mxb_otp_rom_tb;
  localparam int HI_W    = 3;
  localparam int DW      = 8;
  localparam int ALE_CYC = 18;
  localparam int OE_CYC  = 9;
  localparam int AW      = HI_W + DW;
  localparam int DEPTH   = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ale = 1'b1;
  logic oe_n = 1'b1;
  logic [HI_W-1:0] addr_hi = '0;
  logic id_mode = 1'b0;
  logic [DW-1:0] bus_in = '0;
  logic [DW-1:0] bus_out;
  logic bus_drive;
  logic ld_en = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [DW-1:0] ld_data = '1;

  always #2 clk = ~clk;

  mxb_otp_rom #(.HI_W(HI_W), .DW(DW), .ALE_CYC(ALE_CYC), .OE_CYC(OE_CYC)) u_dut (
    .clk(clk), .rst(rst), .ale(ale), .oe_n(oe_n), .addr_hi(addr_hi),
    .id_mode(id_mode), .bus_in(bus_in), .bus_out(bus_out), .bus_drive(bus_drive),
    .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string tag_ovr = "";

  // reference state
  logic [DW-1:0] mm [DEPTH];
  logic [DW-1:0] lat_m = '0;
  logic [DW-1:0] rd_m = '1;
  int ale_run = 0;
  int oe_run = 0;

  function automatic logic id_cond(logic im, logic [HI_W-1:0] hi);
    return im && hi[1] && ((hi >> 2) == '0);
  endfunction

  function automatic logic [DW-1:0] id_val(logic [HI_W-1:0] hi);
    return hi[0] ? 8'h9D : 8'h1E;
  endfunction

  task automatic check(string tag, logic [DW:0] act, logic [DW:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s drive/data actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    logic ex_drv;
    logic [DW-1:0] ex_dat;
    logic idn;
    string tg;
    idn = id_cond(id_mode, addr_hi);
    if (rst) begin
      ale_run = 0; oe_run = 0;
    end else begin
      ale_run = ale ? 0 : ale_run + 1;
      oe_run  = oe_n ? 0 : oe_run + 1;
    end
    ex_drv = !rst && (ale_run >= ALE_CYC + 1) && (oe_run >= OE_CYC + 1);
    ex_dat = !ex_drv ? '0 : (idn ? id_val(addr_hi) : rd_m);
    rd_m = mm[{addr_hi, lat_m}];
    if (rst) lat_m = '0;
    else if (ale) lat_m = bus_in;
    if (ld_en) mm[ld_addr] = mm[ld_addr] & ld_data;
    if (tag_ovr != "") tg = tag_ovr;
    else if (!ex_drv) tg = ale ? "R5" : oe_n ? "R4" : (ale_run <= ALE_CYC) ? "R6" : "R7";
    else if (idn) tg = "R8";
    else if (id_mode) tg = "R9";
    else tg = "R3";
    @(posedge clk); #1;
    check(tg, {bus_drive, bus_out}, {ex_drv, ex_dat});
  endtask

  task automatic read_txn(logic [HI_W-1:0] hi, logic [DW-1:0] lo, int pre_oe, int hold,
                          logic idm, int ld_at, logic [AW-1:0] la, logic [DW-1:0] ld);
    ale = 1'b1; oe_n = 1'b1; bus_in = lo; addr_hi = hi; id_mode = idm;
    repeat (1 + $urandom_range(0, 1)) tick();
    ale = 1'b0;
    for (int i = 0; i < pre_oe; i++) begin
      bus_in = DW'($urandom);
      tick();
    end
    oe_n = 1'b0;
    for (int i = 0; i < hold; i++) begin
      bus_in = DW'($urandom);
      if (i == ld_at) begin
        ld_en = 1'b1; ld_addr = la; ld_data = ld;
      end
      tick();
      ld_en = 1'b0;
    end
    oe_n = 1'b1;
    tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    for (int i = 0; i < DEPTH; i++) mm[i] = '1;
    #1;
    tag_ovr = "R1";
    repeat (4) tick();
    rst = 1'b0;
    tick();
    check("R1", {bus_drive, bus_out}, '0);

    // erased byte
    tag_ovr = "R10";
    read_txn(3'h5, 8'h21, 0, 26, 1'b0, -1, '0, '0);

    // clear-only loads
    tag_ovr = "R11";
    ld_en = 1'b1; ld_addr = {3'h2, 8'h77}; ld_data = 8'hF0; tick();
    ld_data = 8'h3C; tick();
    ld_en = 1'b0;
    read_txn(3'h2, 8'h77, 3, 24, 1'b0, -1, '0, '0);

    // same-edge load and read
    tag_ovr = "R12";
    read_txn(3'h1, 8'hA5, 0, 30, 1'b0, 22, {3'h1, 8'hA5}, 8'h5A);

    // latch hold against bus activity
    tag_ovr = "R2";
    read_txn(3'h4, 8'h0C, 5, 25, 1'b0, -1, '0, '0);

    // delay dominated by ale path then by oe path
    tag_ovr = "";
    read_txn(3'h3, 8'h10, 0, 22, 1'b0, -1, '0, '0);
    read_txn(3'h3, 8'h10, 15, 14, 1'b0, -1, '0, '0);

    // identification
    read_txn(3'b010, 8'h00, 0, 22, 1'b1, -1, '0, '0);
    read_txn(3'b011, 8'h00, 0, 22, 1'b1, -1, '0, '0);
    read_txn(3'b110, 8'h00, 0, 22, 1'b1, -1, '0, '0);
    read_txn(3'b001, 8'h00, 0, 22, 1'b1, -1, '0, '0);

    // random traffic
    for (int t = 0; t < 250; t++) begin
      logic [HI_W-1:0] h;
      logic [DW-1:0] l;
      int la_at;
      logic [AW-1:0] la;
      h = HI_W'($urandom_range(0, 1) ? $urandom_range(0, 3) : $urandom);
      l = DW'($urandom_range(0, 1) ? $urandom_range(0, 7) : $urandom);
      la_at = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 25)) : -1;
      la = $urandom_range(0, 1) ? {h, l} : AW'($urandom);
      read_txn(h, l, $urandom_range(0, 14), $urandom_range(4, 28),
               ($urandom_range(0, 4) == 0), la_at, la, DW'($urandom));
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule